// File: doc/BRIEF.md
# Multi-Channel Timer Unit Register Front End

This block is the register front end of a general-purpose timer unit. A single 16-bit prescaler, shared by every channel, counts down once per clock. Each time it passes through zero it reloads and gives all channels a one-cycle tick. Between one and eight timer channels, set by a parameter, count those ticks. Each channel drives its own interrupt line.

Software reaches the unit through a simplified single-cycle port: valid, write, an 8-bit byte address and 32-bit write data. Read data comes back registered on the cycle after the request. The front end decodes the address and routes the access to one of four targets: the prescaler registers, a read-only capability word, or one channel's counter, reload or control register. Accesses that match none of these read as zero and change nothing.

Top module: `tmu_unit`

## Requirements
- R1: Word offsets 0x00, 0x04 and 0x08 hold the prescaler count, the prescaler reload and the capability word. Channel n (n from 0) sits at 0x10 + 16*n, with its counter at +0, reload at +4 and control at +8. Read data appears on `bus_rdata` on the cycle after the request and holds until the next read.
- R2: Writes to the prescaler count and the prescaler reload keep only bits [15:0]. Bits [31:16] of these registers read as zero.
- R3: The following accesses are unmapped: an address with bits [1:0] not zero, word +0x0C of any page, and a page of a channel that does not exist. Reads of an unmapped address return zero, and writes to one change no register.
- R4: The prescaler count drops by one every clock. When it is zero it reloads from the prescaler reload and issues a tick, so ticks come every (reload+1) cycles, and every cycle when the reload is zero.
- R5: The capability word at 0x08 ignores writes. It reads as: channel count in bits [2:0], interrupt base line in bits [7:3], bit 8 = 1 (one interrupt line per channel), bit 9 = 1 (no freeze on debug halt). With the defaults (2 channels, base 8) the word is 0x342.
- R6: After synchronous reset, the prescaler count and reload are zero, every channel's counter, reload and control are zero, and all interrupt lines are low.
- R7: While control bit 0 (enable) is set, a channel's counter drops by one on each tick. While enable is clear, the counter holds. A counter write loads the written value. A counter write or a control write takes the place of the tick in that cycle.
- R8: A tick that finds an enabled counter at zero is an underflow. If control bit 3 (interrupt enable) is set, the underflow sets control bit 4 (pending) and raises that channel's `irq` bit for exactly the following cycle. If control bit 1 (restart) is set, the counter reloads from the channel reload register; otherwise enable clears and the counter stays at zero.
- R9: A control write stores bits 0, 1 and 3. Writing 1 to bit 4 clears pending; writing 0 leaves pending unchanged. Writing 1 to bit 2 (load) copies the reload register into the counter, and bit 2 always reads back as zero.
- R10: Each channel's interrupt line is driven only by that channel's own underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the unit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| irq | output | NCHAN | One interrupt line per channel |

## Verification
Read data lands one edge after the read request. A register write is visible to a read issued on the very next cycle. A counter enabled by a control write on edge k first decrements on edge k+1, provided a tick is present. An underflow on edge u raises `irq` from u until u+1. The bench issues every access at a falling edge and samples each result at a falling edge. It places enables, idle cycles and reads so that each expected counter value and interrupt level falls on a known edge, then compares there. Reads are queued with their expected values as they are issued, and a monitor compares them one cycle later against `bus_rdata`.

// File: rtl/tmu_pkg.sv
// Shared constants for the timer unit: data width, register kinds
// and control-bit positions. Assumes 32-bit word-aligned registers.
package tmu_pkg;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 16;

    typedef enum logic [1:0] {
        RK_COUNT  = 2'd0,
        RK_RELOAD = 2'd1,
        RK_CTRL   = 2'd2,
        RK_NONE   = 2'd3
    } reg_kind_e;

    localparam int CTL_EN  = 0;
    localparam int CTL_RST = 1;
    localparam int CTL_LD  = 2;
    localparam int CTL_IE  = 3;
    localparam int CTL_IP  = 4;
endpackage

// File: rtl/tmu_prescaler.sv
// Shared prescaler: a down-counter that reloads on zero and emits a
// combinational tick in that cycle. Assumes the write strobes are
// already qualified by the address decoder.
module tmu_prescaler
    import tmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val,
    input  logic             wr_rel,
    input  logic [PRE_W-1:0] wdata,
    output logic [PRE_W-1:0] cnt,
    output logic [PRE_W-1:0] rel,
    output logic             tick
);
    // tick whenever the count has reached zero
    assign tick = (cnt == '0);

    // count/reload registers; a count write wins over the reload step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            rel <= '0;
        end else begin
            if (wr_rel) rel <= wdata;
            if (wr_val)     cnt <= wdata;
            else if (tick)  cnt <= rel;
            else            cnt <= cnt - 1'b1;
        end
    end

    AST_PRE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !wr_val) |=> cnt == $past(rel)); // R4
    AST_PRE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !wr_val) |=> cnt == $past(cnt) - 1'b1); // R4
endmodule

// File: rtl/tmu_decode.sv
// Address decoder: splits the 8-bit byte address into unit-register
// selects and per-channel selects. Misaligned addresses, word 3 of
// any page and pages of absent channels select nothing.
module tmu_decode
    import tmu_pkg::*;
#(
    parameter int NCHAN = 2
) (
    input  logic [7:0]       addr,
    output logic             sel_pval,
    output logic             sel_prel,
    output logic             sel_cap,
    output logic [NCHAN-1:0] sel_ch,
    output reg_kind_e        kind,
    output logic             hit
);
    logic       aligned;
    logic [3:0] page;
    logic [1:0] word;

    // split address into page and word fields
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        page    = addr[7:4];
        word    = addr[3:2];
        kind    = reg_kind_e'(word);
    end

    // unit-register selects live in page 0
    always_comb begin
        sel_pval = aligned && page == 4'd0 && word == 2'd0;
        sel_prel = aligned && page == 4'd0 && word == 2'd1;
        sel_cap  = aligned && page == 4'd0 && word == 2'd2;
    end

    // one select per existing channel, page n+1
    for (genvar i = 0; i < NCHAN; i++) begin : g_sel
        assign sel_ch[i] = aligned && page == 4'(i + 1) && word != 2'd3;
    end

    assign hit = sel_pval | sel_prel | sel_cap | (|sel_ch);
endmodule

// File: rtl/tmu_channel.sv
// One timer channel: 32-bit counter, reload and control bits. Counts
// down on the shared tick while enabled; on underflow optionally flags
// pending, pulses its interrupt and reloads or stops. Register writes
// to counter or control take precedence over the tick that cycle.
module tmu_channel
    import tmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] counter;
    logic [DATA_W-1:0] reload;
    logic en, restart, ie, pend;
    logic wr_cnt, wr_ctl, wr_rld;

    // qualify the write by register kind
    always_comb begin
        wr_cnt = wr && kind == RK_COUNT;
        wr_rld = wr && kind == RK_RELOAD;
        wr_ctl = wr && kind == RK_CTRL;
    end

    // channel state: writes first, else counting and underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            counter <= '0;
            reload  <= '0;
            en      <= 1'b0;
            restart <= 1'b0;
            ie      <= 1'b0;
            pend    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (wr_rld) reload <= wdata;
            if (wr_ctl) begin
                en      <= wdata[CTL_EN];
                restart <= wdata[CTL_RST];
                ie      <= wdata[CTL_IE];
                if (wdata[CTL_IP]) pend <= 1'b0;
                if (wdata[CTL_LD]) counter <= reload;
            end else if (wr_cnt) begin
                counter <= wdata;
            end else if (tick && en) begin
                if (counter == '0) begin
                    if (ie) begin
                        pend <= 1'b1;
                        irq  <= 1'b1;
                    end
                    if (restart) counter <= reload;
                    else         en      <= 1'b0;
                end else begin
                    counter <= counter - 1'b1;
                end
            end
        end
    end

    // read view of the selected register
    always_comb begin
        unique case (kind)
            RK_COUNT:  rdata = counter;
            RK_RELOAD: rdata = reload;
            RK_CTRL:   rdata = {27'd0, pend, ie, 1'b0, restart, en};
            default:   rdata = '0;
        endcase
    end

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_cnt && !wr_ctl) |=> counter == $past(counter)); // R7
    AST_IRQ_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend); // R8
endmodule

// File: rtl/tmu_unit.sv
// Top of the timer unit front end: decodes single-cycle accesses,
// hosts the shared prescaler, the capability word and NCHAN channels,
// and returns registered read data one cycle after a read request.
module tmu_unit
    import tmu_pkg::*;
#(
    parameter int NCHAN    = 2,
    parameter int IRQ_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCHAN-1:0]  irq
);
    localparam logic [2:0]        NCH_FIELD  = 3'(NCHAN);
    localparam logic [4:0]        BASE_FIELD = 5'(IRQ_BASE);
    localparam logic [DATA_W-1:0] CAP_WORD   =
        {22'd0, 1'b1, 1'b1, BASE_FIELD, NCH_FIELD};

    logic              sel_pval, sel_prel, sel_cap, hit;
    logic [NCHAN-1:0]  sel_ch;
    reg_kind_e         kind;
    logic [PRE_W-1:0]  pre_cnt, pre_rel;
    logic              tick;
    logic              do_wr, do_rd;
    logic [DATA_W-1:0] ch_rdata [NCHAN];
    logic [DATA_W-1:0] rd_next;

    assign do_wr = bus_valid &&  bus_write;
    assign do_rd = bus_valid && !bus_write;

    tmu_decode #(.NCHAN(NCHAN)) u_dec (
        .addr     (bus_addr),
        .sel_pval (sel_pval),
        .sel_prel (sel_prel),
        .sel_cap  (sel_cap),
        .sel_ch   (sel_ch),
        .kind     (kind),
        .hit      (hit)
    );

    tmu_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_val (do_wr && sel_pval),
        .wr_rel (do_wr && sel_prel),
        .wdata  (bus_wdata[PRE_W-1:0]),
        .cnt    (pre_cnt),
        .rel    (pre_rel),
        .tick   (tick)
    );

    for (genvar i = 0; i < NCHAN; i++) begin : g_ch
        tmu_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .wr    (do_wr && sel_ch[i]),
            .kind  (kind),
            .wdata (bus_wdata),
            .rdata (ch_rdata[i]),
            .irq   (irq[i])
        );
    end

    // read mux: OR of whichever target is selected, zero when none
    always_comb begin
        rd_next = '0;
        if (sel_pval) rd_next = {{(DATA_W-PRE_W){1'b0}}, pre_cnt};
        if (sel_prel) rd_next = {{(DATA_W-PRE_W){1'b0}}, pre_rel};
        if (sel_cap)  rd_next = CAP_WORD;
        for (int i = 0; i < NCHAN; i++) begin
            if (sel_ch[i]) rd_next = rd_next | ch_rdata[i];
        end
    end

    // registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= '0;
        else if (do_rd) bus_rdata <= rd_next;
    end

    AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && !hit) |=> bus_rdata == '0); // R3
    AST_CAP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && bus_addr == 8'h08) |=> bus_rdata == CAP_WORD); // R5
endmodule

// File: tb/tb_tmu_unit.sv
`timescale 1ns/1ps
module tb_tmu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sbq[$];
    logic rd_issued = 1'b0;

    always #2.5 clk = ~clk;

    tmu_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // marks the edges at which a read was captured
    always @(posedge clk) rd_issued <= rst_n && bus_valid && !bus_write;

    // monitor: compare each captured read against the queued expectation
    always @(negedge clk) begin
        if (rd_issued) begin
            exp_t e;
            n_chk++;
            if (sbq.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read with no expectation, got %h", bus_rdata);
            end else begin
                e = sbq.pop_front();
                if (bus_rdata !== e.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", e.tag, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sbq.push_back('{exp: e, tag: tag});
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic idle();
        bus_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_irq(2'b00, "R6 irq after reset");
        // R6 reset state, R5 capability, R1 map
        rd(8'h00, 32'h0, "R6 prescaler count");
        rd(8'h04, 32'h0, "R6 prescaler reload");
        rd(8'h08, 32'h342, "R5 capability");
        rd(8'h10, 32'h0, "R6 ch0 counter");
        rd(8'h14, 32'h0, "R6 ch0 reload");
        rd(8'h18, 32'h0, "R6 ch0 control");
        rd(8'h28, 32'h0, "R6 ch1 control");
        // R2 16-bit prescaler fields, R4 decrement
        wr(8'h04, 32'hABCD1234);
        rd(8'h04, 32'h1234, "R2 reload low half");
        wr(8'h00, 32'hFFFF0100);
        rd(8'h00, 32'h100, "R2 count low half");
        rd(8'h00, 32'hFF, "R4 count decrements");
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0);
        // R5 write ignored
        wr(8'h08, 32'hFFFFFFFF);
        rd(8'h08, 32'h342, "R5 capability after write");
        // R3 unmapped
        wr(8'h12, 32'h5);
        rd(8'h10, 32'h0, "R3 misaligned write ignored");
        wr(8'h30, 32'hFFFF);
        rd(8'h30, 32'h0, "R3 absent channel");
        rd(8'h0C, 32'h0, "R3 unit word 3");
        rd(8'h1C, 32'h0, "R3 channel word 3");
        rd(8'hF0, 32'h0, "R3 high page");
        rd(8'h11, 32'h0, "R3 misaligned read");
        // R7 counting with tick every cycle
        wr(8'h14, 32'd3);
        rd(8'h14, 32'd3, "R1 ch0 reload");
        wr(8'h10, 32'd10);
        wr(8'h18, 32'h1);
        rd(8'h10, 32'd10, "R7 count first");
        rd(8'h10, 32'd9, "R7 count step");
        wr(8'h18, 32'h0);
        rd(8'h10, 32'd8, "R7 stop");
        idle(); idle();
        rd(8'h10, 32'd8, "R7 hold while disabled");
        // R8 underflow with restart and interrupt
        wr(8'h10, 32'd1);
        wr(8'h18, 32'hB);
        idle();
        chk_irq(2'b00, "R8 no irq before underflow");
        idle();
        chk_irq(2'b01, "R8 R10 ch0 irq pulse");
        rd(8'h18, 32'h1B, "R8 pending set");
        chk_irq(2'b00, "R8 irq one cycle");
        rd(8'h10, 32'd2, "R8 restart reload");
        wr(8'h18, 32'h10);
        rd(8'h18, 32'h0, "R9 pending cleared");
        rd(8'h10, 32'd1, "R7 hold after disable");
        // R8 one-shot on channel 1
        wr(8'h24, 32'd7);
        wr(8'h20, 32'd0);
        wr(8'h28, 32'h9);
        idle();
        chk_irq(2'b10, "R10 ch1 irq only");
        rd(8'h28, 32'h18, "R8 one-shot clears enable");
        wr(8'h28, 32'h8);
        rd(8'h28, 32'h18, "R9 pending kept");
        rd(8'h20, 32'd0, "R8 counter stays zero");
        // R9 load
        wr(8'h28, 32'h14);
        rd(8'h28, 32'h0, "R9 load reads zero");
        rd(8'h20, 32'd7, "R9 load copies reload");
        // R4 divided tick: reload 2 gives a tick every 3 cycles
        wr(8'h04, 32'd2);
        wr(8'h00, 32'd2);
        wr(8'h10, 32'd20);
        wr(8'h18, 32'h1);
        rd(8'h10, 32'd20, "R4 div a");
        rd(8'h10, 32'd19, "R4 div b");
        rd(8'h10, 32'd19, "R4 div c");
        rd(8'h10, 32'd19, "R4 div d");
        rd(8'h10, 32'd18, "R4 div e");
        idle(); idle();
        n_chk++;
        if (sbq.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d reads unanswered, expected 0", sbq.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule